// File: doc/BRIEF.md
# Sequenced ARX Cipher Round

This block computes one encryption round of a 64-bit block cipher made only from modular addition, fixed rotations and XOR on two 32-bit words. It does not evaluate the round in a single combinational pass. A small state machine steps through the round and performs one sub-operation in each clock cycle. A round controller outside this block pulses `start` and keeps the two data words and the round subkey steady. It then waits for `done`, reads the two result words, and may start the next round at once.

The round sets the first word to the rotated first word plus the second word, modulo 2^32, XORed with the subkey. It then sets the second word to the second word rotated left by three, XORed with the new first word. The working registers are internal. The result words and `done` are registered, and they keep their values until a new result replaces them.

Top module: `arx_round`

## Requirements
- R1: A synchronous active-high `rst` puts the machine into the idle state (code 4'b0000) and clears `done`, `x_out` and `y_out` to zero. This also applies in the middle of a round, and the interrupted round never raises `done`.
- R2: A `start` seen at a rising edge while idle is accepted. The machine moves to state 4'b0001, and `done` is low after that edge.
- R3: After an accepted start, the states 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101 and 4'b0110 follow one per clock, and the machine then returns to idle. `done` rises at the sixth rising edge after the edge that accepted `start`.
- R4: `x_out` equals ((x_in rotated right by 8) + y_in) mod 2^32, XORed with `round_key`. `x_in`, `y_in` and `round_key` are held from the accepted start until `done` rises.
- R5: `y_out` equals (y_in rotated left by 3) XOR the new `x_out`.
- R6: `done`, `x_out` and `y_out` keep their values until the next accepted start. The old result words stay visible while the next round runs, until that round's final state writes new ones.
- R7: A `start` that arrives while a round is in progress, including in the final state 4'b0110, has no effect. The running round's result and timing are unchanged, and `done` does not fall afterwards.
- R8: The addition discards its carry out, so operands whose sum reaches 2^32 or more wrap around.
- R9: A `start` driven in the first idle cycle after `done` rises is accepted, so rounds can run back to back every seven cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a round; sampled only when idle |
| x_in | input | 32 | First data word, rotated right and added |
| y_in | input | 32 | Second data word, rotated left |
| round_key | input | 32 | Round subkey XORed into the sum |
| x_out | output | 32 | Registered first result word |
| y_out | output | 32 | Registered second result word |
| done | output | 1 | Result valid; high until the next accepted start |

## Verification
Two events can land on the same clock edge here. One is a new `start` request. The other is the final state, which writes the result and raises `done`. The bench drives `start` so that the edge sampling it is the one where the machine leaves state 4'b0110. That start must be ignored, and `done` must stay high over the following idle cycles. In other runs `start` is driven in the very next idle cycle, and that start must be accepted. It is judged by `done` falling at once while the old result words stay on the outputs, and by the new result arriving seven cycles after the previous one. Requests in earlier busy states are also injected at random, and each result is compared with the round computed in the bench.

// File: rtl/arx_round_pkg.sv
package arx_round_pkg;

  typedef enum logic [3:0] {
    S_IDLE = 4'b0000,
    S_LOAD = 4'b0001,
    S_RORX = 4'b0010,
    S_ADD  = 4'b0011,
    S_XKEY = 4'b0100,
    S_MIX  = 4'b0101,
    S_DONE = 4'b0110
  } state_e;

endpackage

// File: rtl/arx_round_ctrl.sv
module arx_round_ctrl
  import arx_round_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output state_e state_q
);

  state_e state_d;

  always_comb begin
    case (state_q)
      S_IDLE:  state_d = start ? S_LOAD : S_IDLE;
      S_LOAD:  state_d = S_RORX;
      S_RORX:  state_d = S_ADD;
      S_ADD:   state_d = S_XKEY;
      S_XKEY:  state_d = S_MIX;
      S_MIX:   state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/arx_round_dp.sv
module arx_round_dp
  import arx_round_pkg::*;
#(
  parameter int W     = 32,
  parameter int ROT_R = 8,
  parameter int ROT_L = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  state_e       state_q,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] round_key,
  output logic [W-1:0] wx_q,
  output logic [W-1:0] wy_q
);

  localparam int RR_C = W - ROT_R;
  localparam int RL_C = W - ROT_L;

  logic [W-1:0] x_rot;
  logic [W-1:0] y_rot;
  logic [W-1:0] sum;

  assign x_rot = (wx_q >> ROT_R) | (wx_q << RR_C);
  assign y_rot = (wy_q << ROT_L) | (wy_q >> RL_C);
  assign sum   = wx_q + wy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wx_q <= '0;
      wy_q <= '0;
    end else begin
      case (state_q)
        S_LOAD: begin
          wx_q <= x_in;
          wy_q <= y_in;
        end
        S_RORX: wx_q <= x_rot;
        S_ADD:  wx_q <= sum;
        S_XKEY: begin
          wx_q <= wx_q ^ round_key;
          wy_q <= y_rot;
        end
        S_MIX:  wy_q <= wy_q ^ wx_q;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/arx_round_out.sv
module arx_round_out
  import arx_round_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  state_e       state_q,
  input  logic [W-1:0] wx_q,
  input  logic [W-1:0] wy_q,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic         done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_out <= '0;
      y_out <= '0;
      done  <= 1'b0;
    end else if (state_q == S_DONE) begin
      x_out <= wx_q;
      y_out <= wy_q;
      done  <= 1'b1;
    end else if (state_q == S_IDLE && start) begin
      done  <= 1'b0;
    end
  end

endmodule

// File: rtl/arx_round.sv
module arx_round
  import arx_round_pkg::*;
#(
  parameter int W     = 32,
  parameter int ROT_R = 8,
  parameter int ROT_L = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] round_key,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic         done
);

  state_e       state_q;
  logic [W-1:0] wx_q;
  logic [W-1:0] wy_q;

  arx_round_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .state_q (state_q)
  );

  arx_round_dp #(.W(W), .ROT_R(ROT_R), .ROT_L(ROT_L)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .x_in      (x_in),
    .y_in      (y_in),
    .round_key (round_key),
    .wx_q      (wx_q),
    .wy_q      (wy_q)
  );

  arx_round_out #(.W(W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .state_q (state_q),
    .wx_q    (wx_q),
    .wy_q    (wy_q),
    .x_out   (x_out),
    .y_out   (y_out),
    .done    (done)
  );

endmodule

// File: rtl/arx_round_chk.sv
module arx_round_chk
  import arx_round_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [3:0]   state,
  input logic         done,
  input logic [W-1:0] x_out,
  input logic [W-1:0] y_out
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (state == S_IDLE && !done && x_out == '0 && y_out == '0));

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start) |=> (state == S_LOAD && !done));

  assert_step_order_R3: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && state != S_DONE) |=> (state == $past(state) + 4'd1));

  assert_final_state_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_DONE) |=> (state == S_IDLE && done));

  assert_legal_code_R3: assert property (@(posedge clk) disable iff (rst)
    state <= S_DONE);

  assert_words_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(state) != S_DONE) |-> ($stable(x_out) && $stable(y_out)));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !(state == S_IDLE && start)) |=> done);

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && start) |=> (state != S_LOAD));

endmodule

bind arx_round arx_round_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .state (state_q),
  .done  (done),
  .x_out (x_out),
  .y_out (y_out)
);

// File: tb/arx_round_tb.sv
module arx_round_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] x_in = '0;
  logic [31:0] y_in = '0;
  logic [31:0] round_key = '0;
  logic [31:0] x_out;
  logic [31:0] y_out;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit summary_done = 1'b0;
  bit have_prev = 1'b0;
  logic [31:0] prev_x = '0;
  logic [31:0] prev_y = '0;

  always #4 clk = ~clk;

  arx_round u_dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .x_in      (x_in),
    .y_in      (y_in),
    .round_key (round_key),
    .x_out     (x_out),
    .y_out     (y_out),
    .done      (done)
  );

  function automatic logic [31:0] exp_x(logic [31:0] a, logic [31:0] b, logic [31:0] k);
    logic [31:0] r;
    r = {a[7:0], a[31:8]};
    return (r + b) ^ k;
  endfunction

  function automatic logic [31:0] exp_y(logic [31:0] b, logic [31:0] nx);
    return {b[28:0], b[31:29]} ^ nx;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the negedge after the edge that raises done.
  // inject: 0 = none, 1..5 = pulse start during busy, the edge sampling it is e(inject+1).
  task automatic run_round(logic [31:0] a, logic [31:0] b, logic [31:0] k, int inject);
    logic [31:0] ex;
    logic [31:0] ey;
    ex = exp_x(a, b, k);
    ey = exp_y(b, ex);
    x_in = a; y_in = b; round_key = k;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R2", {31'b0, done}, 32'd0);
    if (have_prev) begin
      chk(x_out == prev_x, "R6", x_out, prev_x);
      chk(y_out == prev_y, "R6", y_out, prev_y);
    end
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      start = (i == inject);
      chk(done == 1'b0, "R3", {31'b0, done}, 32'd0);
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R3", {31'b0, done}, 32'd1);
    chk(x_out == ex, "R4", x_out, ex);
    chk(y_out == ey, "R5", y_out, ey);
    if (inject != 0) chk(x_out == ex, "R7", x_out, ex);
    prev_x = ex; prev_y = ey; have_prev = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", {31'b0, done}, 32'd0);
    chk(x_out == 32'd0, "R1", x_out, 32'd0);
    chk(y_out == 32'd0, "R1", y_out, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R8: carry wraps
    run_round(32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 0);
    chk(x_out == 32'h0, "R8", x_out, 32'h0);
    chk(y_out == 32'h8, "R8", y_out, 32'h8);
    @(negedge clk);
    run_round(32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 0);
    run_round(32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_F0F0, 0);

    // R7: start in final state collides with done edge; must be ignored
    run_round(32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h5555_AAAA, 5);
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b1, "R7", {31'b0, done}, 32'd1);
      chk(x_out == prev_x, "R6", x_out, prev_x);
    end
    run_round(32'h8000_0001, 32'h7FFF_FFFF, 32'h1357_9BDF, 2);

    // R9: back-to-back, start in the first idle cycle
    run_round(32'hA5A5_5A5A, 32'h0102_0304, 32'hFFFF_0000, 0);
    run_round(32'h0BAD_F00D, 32'hF00D_0BAD, 32'h0000_FFFF, 0);
    chk(done == 1'b1, "R9", {31'b0, done}, 32'd1);

    // R1: reset mid-round
    x_in = 32'h1111_2222; y_in = 32'h3333_4444; round_key = 32'h5555_6666;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(done == 1'b0, "R1", {31'b0, done}, 32'd0);
    chk(x_out == 32'd0, "R1", x_out, 32'd0);
    have_prev = 1'b0;
    repeat (8) begin
      @(negedge clk);
      chk(done == 1'b0, "R1", {31'b0, done}, 32'd0);
    end

    // Random rounds with random busy starts and idle gaps
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] k;
      int inj;
      a = $urandom; b = $urandom; k = $urandom;
      inj = $urandom_range(0, 6);
      if (inj > 5) inj = 0;
      run_round(a, b, k, inj);
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        chk(done == 1'b1, "R6", {31'b0, done}, 32'd1);
      end
    end

    if (!summary_done) begin
      summary_done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!summary_done) begin
      summary_done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end

endmodule